// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block watches a two-wire bus that is oversampled by the system clock. It finds the START and STOP conditions and shifts in the address phase that follows each START. Every incoming line passes first through a synchronizer and a glitch filter. The first byte after a START is sorted into one of seven classes: plain 7-bit address, 10-bit header, general call, START byte, CBUS access, high-speed master code or reserved code. In 10-bit mode the block also takes in the second byte and compares it. When the address belongs to this slave, the block pulls SDA low for the ninth clock. It records the direction bit and gives a one-clock pulse for each event it detects.

The configuration is the own address, a mode select and a general-call enable. Nothing streams through the block, so every pin is a plain level or pulse and there is no valid/ready handshake. After the address phase, the block releases the bus and waits for the next START or STOP. Data bytes and clock stretching belong to other logic.

Top module: `i2c_addr_recognizer`

## Requirements
- R1: A falling SDA while SCL is high gives one `start_det` pulse. A rising SDA while SCL is high gives one `stop_det` pulse. Both are one clock wide.
- R2: With `mode_10bit`=0, a first byte whose bits 7:1 equal `own_addr[6:0]` is acknowledged. `addr_match` pulses once and `rw_dir` takes bit 0 (1 = master reads). A different address is not acknowledged.
- R3: `sda_oe` is set at the SCL falling edge that ends bit 0 of an acknowledged byte and cleared at the next SCL falling edge. It never rises while the filtered SCL is high and is low at every other time.
- R4: With `mode_10bit`=1, a first byte of 11110 followed by `own_addr[9:8]` and direction 0 is acknowledged. A second byte equal to `own_addr[7:0]` is then acknowledged and gives `addr_match` with `rw_dir`=0. A second byte that differs is not acknowledged.
- R5: After a matched 10-bit write addressing, a repeated START followed by the same header with direction 1 is acknowledged and gives `addr_match` with `rw_dir`=1. The same header is not acknowledged after a STOP.
- R6: First byte 0x00 is a general call. With `gc_enable`=1 it is acknowledged and `gcall_hit` pulses. With `gc_enable`=0 there is neither an acknowledge nor a pulse.
- R7: First byte 0x01 is a START byte. `start_byte_hit` pulses and there is no acknowledge.
- R8: Bits 7:1 equal to 0000001 (bytes 0x02 and 0x03) are a CBUS access. `cbus_hit` pulses and there is no acknowledge.
- R9: Bits 7:1 equal to 00001XX (bytes 0x08 to 0x0F) give `hs_code_hit`. Bits 7:1 equal to 0000010, 0000011 or 11111XX give `reserved_hit`. Neither is acknowledged.
- R10: In 10-bit mode a 7-bit address equal to `own_addr[6:0]` is not acknowledged. In 7-bit mode a 10-bit header is not acknowledged.
- R11: A START or a STOP in the middle of a byte throws away the bits already taken in. The byte after a new START is decoded from its own eight bits only.
- R12: A pulse on SCL or SDA that lasts less than `FILT_LEN` system clocks does not reach the bit sampler.
- R13: `addr_match` and the five class flags are one-clock pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| own_addr | input | 10 | Own slave address (bits 6:0 are used in 7-bit mode) |
| mode_10bit | input | 1 | 1 selects 10-bit addressing |
| gc_enable | input | 1 | 1 accepts the general call |
| sda_oe | output | 1 | Open-drain pull-down enable for SDA |
| rw_dir | output | 1 | Direction of the last matched address (1 = read) |
| start_det | output | 1 | START condition pulse |
| stop_det | output | 1 | STOP condition pulse |
| addr_match | output | 1 | Own address matched (pulse) |
| gcall_hit | output | 1 | General call accepted (pulse) |
| start_byte_hit | output | 1 | START byte seen (pulse) |
| cbus_hit | output | 1 | CBUS access ignored (pulse) |
| hs_code_hit | output | 1 | High-speed master code seen (pulse) |
| reserved_hit | output | 1 | Reserved first byte seen (pulse) |

## Verification
The assertions assume that `own_addr`, `mode_10bit` and `gc_enable` stay fixed from a START to the next STOP. They also assume that every SCL level the bus master intends lasts well beyond the synchronizer and filter delay, so the filtered lines keep their order of edges. The stimulus follows both rules. It uses bus quarter-periods of 16 system clocks and changes configuration only while the bus is idle. The only short pulse it drives is the one deliberate SCL glitch, which lasts one clock.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
  localparam int BYTE_BITS = 8;
  localparam int ADDR_BITS = 10;

  typedef enum logic [2:0] {
    CLS_ADDR7, CLS_HDR10, CLS_GCALL, CLS_SBYTE, CLS_CBUS, CLS_HSMC, CLS_RSVD
  } fb_class_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SHIFT, PH_WAIT_ACK, PH_ACK, PH_IGNORE
  } phase_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   sync_last;

  assign sync_last = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_last};
      // output moves only when the whole history agrees
      if (&hist_q)       line_o <= 1'b1;
      else if (~|hist_q) line_o <= 1'b0;
    end
  end

  // a change of the filtered level must follow the synchronized level
  assert_filter_unanimous_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (line_o != $past(line_o)) |-> (line_o == $past(sync_last, 2)));
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_f;
      sda_prev <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_prev;
  assign scl_fall  = ~scl_f & scl_prev;
  assign start_evt = scl_f & scl_prev & sda_prev & ~sda_f;
  assign stop_evt  = scl_f & scl_prev & ~sda_prev & sda_f;

  // a START needs SDA high beforehand, so two in a row cannot happen
  assert_start_spaced_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !start_evt);
endmodule

// File: rtl/i2c_first_byte_decode.sv
module i2c_first_byte_decode
  import i2c_addr_pkg::*;
(
  input  logic [BYTE_BITS-1:0] byte_i,
  output fb_class_e            cls_o
);
  always_comb begin
    if (byte_i[7:1] == 7'b0000000)      cls_o = byte_i[0] ? CLS_SBYTE : CLS_GCALL;
    else if (byte_i[7:1] == 7'b0000001) cls_o = CLS_CBUS;
    else if (byte_i[7:2] == 6'b000001)  cls_o = CLS_RSVD;
    else if (byte_i[7:3] == 5'b00001)   cls_o = CLS_HSMC;
    else if (byte_i[7:3] == 5'b11111)   cls_o = CLS_RSVD;
    else if (byte_i[7:3] == 5'b11110)   cls_o = CLS_HDR10;
    else                                cls_o = CLS_ADDR7;
  end
endmodule

// File: rtl/i2c_addr_recognizer.sv
module i2c_addr_recognizer
  import i2c_addr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic [ADDR_BITS-1:0] own_addr,
  input  logic                 mode_10bit,
  input  logic                 gc_enable,
  output logic                 sda_oe,
  output logic                 rw_dir,
  output logic                 start_det,
  output logic                 stop_det,
  output logic                 addr_match,
  output logic                 gcall_hit,
  output logic                 start_byte_hit,
  output logic                 cbus_hit,
  output logic                 hs_code_hit,
  output logic                 reserved_hit
);
  localparam int BIT_CW = $clog2(BYTE_BITS);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_BITS - 1);

  // line conditioning, one chain per bus wire (0 = SCL, 1 = SDA)
  logic [1:0] raw_lines, filt_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_i(raw_lines[g]), .line_o(filt_lines[g]));
  end

  logic scl_f, sda_f, scl_rise, scl_fall, start_evt, stop_evt;
  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  i2c_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt));

  phase_e                 phase_q;
  logic [BIT_CW-1:0]      bit_cnt_q;
  logic [BYTE_BITS-2:0]   shift_q;
  logic                   second_q, ack_plan_q, go_second_q, armed_q;
  logic [BYTE_BITS-1:0]   byte_now;
  fb_class_e              cls;

  assign byte_now = {shift_q, sda_f};

  i2c_first_byte_decode u_decode (.byte_i(byte_now), .cls_o(cls));

  // decision for the byte completing on this SCL rise
  logic d_ack, d_second, d_match, d_rw, d_arm;
  logic d_gc, d_sb, d_cb, d_hs, d_rs;

  always_comb begin
    d_ack = 1'b0; d_second = 1'b0; d_match = 1'b0; d_rw = byte_now[0]; d_arm = 1'b0;
    d_gc = 1'b0; d_sb = 1'b0; d_cb = 1'b0; d_hs = 1'b0; d_rs = 1'b0;
    if (second_q) begin
      if (byte_now == own_addr[7:0]) begin
        d_ack = 1'b1; d_match = 1'b1; d_rw = 1'b0; d_arm = 1'b1;
      end
    end else begin
      unique case (cls)
        CLS_ADDR7: if (!mode_10bit && byte_now[7:1] == own_addr[6:0]) begin
          d_ack = 1'b1; d_match = 1'b1;
        end
        CLS_HDR10: if (mode_10bit && byte_now[2:1] == own_addr[9:8]) begin
          if (!byte_now[0]) begin
            d_ack = 1'b1; d_second = 1'b1;
          end else if (armed_q) begin
            d_ack = 1'b1; d_match = 1'b1; d_arm = 1'b1;
          end
        end
        CLS_GCALL: if (gc_enable) begin
          d_ack = 1'b1; d_gc = 1'b1;
        end
        CLS_SBYTE: d_sb = 1'b1;
        CLS_CBUS:  d_cb = 1'b1;
        CLS_HSMC:  d_hs = 1'b1;
        CLS_RSVD:  d_rs = 1'b1;
        default:   d_rs = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE; bit_cnt_q <= '0; shift_q <= '0;
      second_q <= 1'b0; ack_plan_q <= 1'b0; go_second_q <= 1'b0; armed_q <= 1'b0;
      sda_oe <= 1'b0; rw_dir <= 1'b0;
      start_det <= 1'b0; stop_det <= 1'b0; addr_match <= 1'b0;
      gcall_hit <= 1'b0; start_byte_hit <= 1'b0; cbus_hit <= 1'b0;
      hs_code_hit <= 1'b0; reserved_hit <= 1'b0;
    end else begin
      start_det <= 1'b0; stop_det <= 1'b0; addr_match <= 1'b0;
      gcall_hit <= 1'b0; start_byte_hit <= 1'b0; cbus_hit <= 1'b0;
      hs_code_hit <= 1'b0; reserved_hit <= 1'b0;
      if (start_evt) begin
        phase_q <= PH_SHIFT; bit_cnt_q <= '0; second_q <= 1'b0;
        sda_oe <= 1'b0; start_det <= 1'b1;
      end else if (stop_evt) begin
        phase_q <= PH_IDLE; sda_oe <= 1'b0; armed_q <= 1'b0; stop_det <= 1'b1;
      end else begin
        unique case (phase_q)
          PH_SHIFT: if (scl_rise) begin
            shift_q   <= byte_now[BYTE_BITS-2:0];
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == LAST_BIT) begin
              phase_q     <= PH_WAIT_ACK;
              ack_plan_q  <= d_ack;
              go_second_q <= d_second;
              armed_q     <= d_arm;
              addr_match  <= d_match;
              if (d_match) rw_dir <= d_rw;
              gcall_hit <= d_gc; start_byte_hit <= d_sb; cbus_hit <= d_cb;
              hs_code_hit <= d_hs; reserved_hit <= d_rs;
            end
          end
          PH_WAIT_ACK: if (scl_fall) begin
            if (ack_plan_q) begin
              sda_oe <= 1'b1; phase_q <= PH_ACK;
            end else begin
              phase_q <= PH_IGNORE;
            end
          end
          PH_ACK: if (scl_fall) begin
            sda_oe    <= 1'b0;
            bit_cnt_q <= '0;
            second_q  <= go_second_q;
            phase_q   <= go_second_q ? PH_SHIFT : PH_IGNORE;
          end
          default: phase_q <= phase_q;
        endcase
      end
    end
  end

  // the pull-down only moves on an SCL fall or a bus condition
  assert_oe_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall | start_evt | stop_evt));
  assert_oe_rise_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(!scl_f));
  assert_gc_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gcall_hit |-> gc_enable);
  assert_flags_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_match, gcall_hit, start_byte_hit, cbus_hit, hs_code_hit, reserved_hit}));
  assert_match_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |=> !addr_match);
endmodule

// File: tb/i2c_addr_recognizer_bench.sv
module i2c_addr_recognizer_bench;
  localparam int QT = 64;            // bus quarter period in ns (16 clocks)
  localparam int WD_NS = 190000 * 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [9:0] own_addr = 10'h05A;
  logic mode_10bit = 1'b0, gc_enable = 1'b0;
  logic sda_oe, rw_dir, start_det, stop_det, addr_match;
  logic gcall_hit, start_byte_hit, cbus_hit, hs_code_hit, reserved_hit;
  logic sda_line;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_addr_recognizer u_i2c_addr_recognizer (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .own_addr(own_addr), .mode_10bit(mode_10bit), .gc_enable(gc_enable),
    .sda_oe(sda_oe), .rw_dir(rw_dir), .start_det(start_det), .stop_det(stop_det),
    .addr_match(addr_match), .gcall_hit(gcall_hit), .start_byte_hit(start_byte_hit),
    .cbus_hit(cbus_hit), .hs_code_hit(hs_code_hit), .reserved_hit(reserved_hit));

  int n_start = 0, n_stop = 0, n_match = 0, n_gc = 0, n_sb = 0, n_cb = 0, n_hs = 0, n_rs = 0;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (start_det)      n_start <= n_start + 1;
    if (stop_det)       n_stop  <= n_stop + 1;
    if (addr_match)     n_match <= n_match + 1;
    if (gcall_hit)      n_gc    <= n_gc + 1;
    if (start_byte_hit) n_sb    <= n_sb + 1;
    if (cbus_hit)       n_cb    <= n_cb + 1;
    if (hs_code_hit)    n_hs    <= n_hs + 1;
    if (reserved_hit)   n_rs    <= n_rs + 1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #QT; scl_m = 1'b1; #QT; sda_m = 1'b0; #QT; scl_m = 1'b0; #QT;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #QT; scl_m = 1'b1; #QT; sda_m = 1'b1; #QT;
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, input int glitch_bit);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_m = b[i];
      if (i == glitch_bit) begin
        #(QT/2); scl_m = 1'b1; #4; scl_m = 1'b0; #(QT/2 - 4);
      end else begin
        #QT;
      end
      scl_m = 1'b1; #(2*QT); scl_m = 1'b0; #QT;
    end
  endtask

  // one address byte plus the ninth clock; checks release afterwards (R3)
  task automatic send_byte(input logic [7:0] b, input int glitch_bit, output bit ack);
    send_bits(b, 8, glitch_bit);
    sda_m = 1'b1; #QT;
    scl_m = 1'b1; #QT;
    ack = sda_oe;
    #QT; scl_m = 1'b0; #QT;
    chk(sda_oe == 1'b0, "R3", "sda_oe released after ninth clock", sda_oe, 0);
  endtask

  task automatic addr_byte(input logic [7:0] b, input bit exp_ack, input string req);
    bit ack;
    send_byte(b, -1, ack);
    chk(ack == exp_ack, req, $sformatf("ack for byte 0x%02h", b), ack, exp_ack);
  endtask

  task automatic t_reset();
    repeat (10) @(negedge clk);
    chk(sda_oe == 1'b0 && rw_dir == 1'b0, "R3", "reset outputs", {sda_oe, rw_dir}, 0);
    chk(n_start + n_stop + n_match + n_gc == 0, "R13", "no pulses after reset", n_start + n_stop, 0);
  endtask

  task automatic t_addr7();
    int s0 = n_start, p0 = n_stop, m0 = n_match;
    mode_10bit = 1'b0; own_addr = 10'h05A;
    bus_start();
    chk(n_start - s0 == 1, "R1", "start pulses", n_start - s0, 1);
    addr_byte({7'h5A, 1'b0}, 1'b1, "R2");
    chk(n_match - m0 == 1 && rw_dir == 1'b0, "R2", "write match/rw", rw_dir, 0);
    bus_stop();
    chk(n_stop - p0 == 1, "R1", "stop pulses", n_stop - p0, 1);
    bus_start(); addr_byte({7'h5A, 1'b1}, 1'b1, "R2"); bus_stop();
    chk(n_match - m0 == 2 && rw_dir == 1'b1, "R2", "read match/rw", rw_dir, 1);
    bus_start(); addr_byte({7'h5B, 1'b0}, 1'b0, "R2"); bus_stop();
    chk(n_match - m0 == 2, "R2", "no match for other address", n_match - m0, 2);
  endtask

  task automatic t_gcall();
    int g0 = n_gc;
    gc_enable = 1'b1;
    bus_start(); addr_byte(8'h00, 1'b1, "R6"); bus_stop();
    chk(n_gc - g0 == 1, "R6", "gc pulse enabled", n_gc - g0, 1);
    gc_enable = 1'b0;
    bus_start(); addr_byte(8'h00, 1'b0, "R6"); bus_stop();
    chk(n_gc - g0 == 1, "R6", "no gc pulse disabled", n_gc - g0, 1);
  endtask

  task automatic t_special();
    int b0 = n_sb, c0 = n_cb, h0 = n_hs, r0 = n_rs, m0 = n_match;
    bus_start(); addr_byte(8'h01, 1'b0, "R7"); bus_stop();
    chk(n_sb - b0 == 1, "R7", "start byte pulse", n_sb - b0, 1);
    bus_start(); addr_byte(8'h02, 1'b0, "R8"); bus_stop();
    bus_start(); addr_byte(8'h03, 1'b0, "R8"); bus_stop();
    chk(n_cb - c0 == 2, "R8", "cbus pulses", n_cb - c0, 2);
    bus_start(); addr_byte(8'h08, 1'b0, "R9"); bus_stop();
    bus_start(); addr_byte(8'h0F, 1'b0, "R9"); bus_stop();
    chk(n_hs - h0 == 2, "R9", "hs code pulses", n_hs - h0, 2);
    bus_start(); addr_byte(8'h04, 1'b0, "R9"); bus_stop();
    bus_start(); addr_byte(8'h07, 1'b0, "R9"); bus_stop();
    bus_start(); addr_byte(8'hF9, 1'b0, "R9"); bus_stop();
    chk(n_rs - r0 == 3, "R9", "reserved pulses", n_rs - r0, 3);
    chk(n_match - m0 == 0, "R13", "no match on special codes", n_match - m0, 0);
  endtask

  task automatic t_ten_bit();
    int m0 = n_match;
    mode_10bit = 1'b1; own_addr = 10'h2C5;
    bus_start(); addr_byte(8'hF4, 1'b1, "R4"); addr_byte(8'hC5, 1'b1, "R4");
    chk(n_match - m0 == 1 && rw_dir == 1'b0, "R4", "10-bit write match", n_match - m0, 1);
    bus_start(); addr_byte(8'hF5, 1'b1, "R5");
    chk(n_match - m0 == 2 && rw_dir == 1'b1, "R5", "10-bit read after repeated start", rw_dir, 1);
    bus_stop();
    bus_start(); addr_byte(8'hF5, 1'b0, "R5"); bus_stop();
    chk(n_match - m0 == 2, "R5", "read header after stop ignored", n_match - m0, 2);
    bus_start(); addr_byte(8'hF4, 1'b1, "R4"); addr_byte(8'hC4, 1'b0, "R4"); bus_stop();
    chk(n_match - m0 == 2, "R4", "second byte mismatch", n_match - m0, 2);
  endtask

  task automatic t_mode_gate();
    int m0 = n_match;
    mode_10bit = 1'b1; own_addr = 10'h2C5;
    bus_start(); addr_byte({7'h45, 1'b0}, 1'b0, "R10"); bus_stop();
    mode_10bit = 1'b0; own_addr = 10'h274;
    bus_start(); addr_byte(8'hF4, 1'b0, "R10"); bus_stop();
    chk(n_match - m0 == 0, "R10", "mode gating", n_match - m0, 0);
  endtask

  task automatic t_abort();
    int m0 = n_match, s0 = n_start, p0 = n_stop;
    mode_10bit = 1'b0; own_addr = 10'h05A;
    bus_start(); send_bits(8'hFF, 3, -1); bus_start();
    addr_byte({7'h5A, 1'b0}, 1'b1, "R11");
    bus_stop();
    bus_start(); send_bits(8'h0F, 4, -1); bus_stop();
    bus_start(); addr_byte({7'h5A, 1'b1}, 1'b1, "R11"); bus_stop();
    chk(n_match - m0 == 2, "R11", "matches after aborts", n_match - m0, 2);
    chk(n_start - s0 == 4 && n_stop - p0 == 3, "R1", "start count with repeats", n_start - s0, 4);
  endtask

  task automatic t_glitch();
    int m0 = n_match;
    bit ack;
    bus_start();
    send_byte({7'h5A, 1'b0}, 4, ack);
    chk(ack == 1'b1, "R12", "ack despite SCL glitch", ack, 1);
    bus_stop();
    chk(n_match - m0 == 1, "R12", "match despite SCL glitch", n_match - m0, 1);
  endtask

  initial begin
    #(WD_NS);
    if (!done) begin
      n_fail++;
      $display("FAIL R1: watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #40; rst_n = 1'b1;
    t_reset();
    t_addr7();
    t_gcall();
    t_special();
    t_ten_bit();
    t_mode_gate();
    t_abort();
    t_glitch();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule